// File: doc/BRIEF.md
# Quadrature Position Counter

This block turns the two phase signals of an incremental rotary or linear encoder into a position count. The count goes up or down by one on every legal edge of either phase, which gives four counts for each full phase cycle. On every rising clock edge the block compares the phase pair on its inputs with the pair it stored on the previous edge. It then counts up, counts down or holds. If both phases change in the same sample, the move has no defined direction, so the block drops it without any indication and keeps decoding from the new pair.

The count is unsigned, its width is set by a parameter, and it wraps in both directions. An asynchronous active-high reset clears the count and the stored phase pair to zero. Because of this, the first sample after reset is decoded against the pair 00. The phase inputs must already be synchronous to the clock. A change on them shows on the count after exactly one rising edge.

Top module: `quad_position_counter`

## Requirements
- R1: The count width is the parameter CNT_W, with a default of 8. The block behaves the same at CNT_W = 3 and at CNT_W = 8.
- R2: With the phase pair written as {A,B}, each step in the order 00, 10, 11, 01, 00 adds one to the count.
- R3: Each step in the order 00, 01, 11, 10, 00 subtracts one from the count.
- R4: Counting up from all-ones gives zero.
- R5: Counting down from zero gives all-ones.
- R6: If the sampled pair equals the stored pair, the count holds.
- R7: If both phases differ from the stored pair (00 to 11, 11 to 00, 10 to 01, 01 to 10), the count holds. The new pair is still stored, so the next legal step counts from it.
- R8: While reset is high, the count reads zero whatever the phase inputs are. Reset acts without waiting for a clock edge.
- R9: While reset is high, the stored pair is 00. If the inputs are 10 when reset falls, the first rising edge adds one.
- R10: A change on the phase inputs reaches the count on the first rising edge after it and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on its rising edge |
| rst | input | 1 | Asynchronous active-high reset |
| phase_a | input | 1 | Encoder phase A, synchronous to clk |
| phase_b | input | 1 | Encoder phase B, synchronous to clk |
| position | output | CNT_W | Wrapping unsigned position count |

## Verification
The bench builds two instances that share one stimulus: one at CNT_W = 3 and one at the default CNT_W = 8. At width 3 a single pass of two forward phase cycles reaches the upper wrap, and one reverse step from zero reaches the lower wrap. The width-8 instance follows the same stream without wrapping, so it shows that a boundary crossing at width 3 is really a wrap and not a hold. A directed pass drives the width-8 instance across both of its own wrap points, and further directed tests check the asynchronous reset and the single-edge latency.

// File: rtl/qdec_pkg.sv
package qdec_pkg;

    // Result of comparing the current phase pair with the stored one.
    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_e;

    // Position of a phase pair {A,B} in the forward Gray order 00,10,11,01.
    function automatic logic [1:0] gray_pos(input logic [1:0] ab);
        case (ab)
            2'b00:   return 2'd0;
            2'b10:   return 2'd1;
            2'b11:   return 2'd2;
            default: return 2'd3;
        endcase
    endfunction

endpackage

// File: rtl/qdec_phase_reg.sv
module qdec_phase_reg (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] phase_i,
    output logic [1:0] prev_o
);
    typedef struct packed {
        logic [1:0] pair;
    } phase_st_t;

    phase_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.pair = phase_i;
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign prev_o = st_q.pair;

    // R9: the stored pair sits at 00 once reset has been seen on an edge
    a_r9_prev_cleared: assert property (@(posedge clk)
        (rst && $past(rst)) |-> (prev_o == 2'b00));

endmodule

// File: rtl/qdec_step.sv
module qdec_step
    import qdec_pkg::*;
(
    input  logic [1:0] prev_i,
    input  logic [1:0] cur_i,
    output step_e      step_o
);
    logic [1:0] dist_d;

    always_comb begin
        dist_d = gray_pos(cur_i) - gray_pos(prev_i);
        case (dist_d)
            2'd1:    step_o = STEP_UP;
            2'd3:    step_o = STEP_DOWN;
            default: step_o = STEP_HOLD;   // unchanged or double jump
        endcase
    end

endmodule

// File: rtl/qdec_count.sv
module qdec_count
    import qdec_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  step_e            step_i,
    output logic [CNT_W-1:0] count_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] count;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        case (step_i)
            STEP_UP:   st_d.count = st_q.count + ONE;
            STEP_DOWN: st_d.count = st_q.count - ONE;
            default:   st_d.count = st_q.count;
        endcase
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign count_o = st_q.count;

    // R4: all-ones stepped up lands on zero
    a_r4_wrap_up: assert property (@(posedge clk) disable iff (rst)
        (count_o == '1 && step_i == STEP_UP) |=> (count_o == '0));

    // R5: zero stepped down lands on all-ones
    a_r5_wrap_down: assert property (@(posedge clk) disable iff (rst)
        (count_o == '0 && step_i == STEP_DOWN) |=> (count_o == '1));

    // R8: count reads zero once reset has been seen on an edge
    a_r8_reset_zero: assert property (@(posedge clk)
        (rst && $past(rst)) |-> (count_o == '0));

    // R10: a decoded step moves the count on the very next edge
    a_r10_one_edge: assert property (@(posedge clk) disable iff (rst)
        (step_i != STEP_HOLD) |=> (count_o != $past(count_o)));

endmodule

// File: rtl/quad_position_counter.sv
module quad_position_counter
    import qdec_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             phase_a,
    input  logic             phase_b,
    output logic [CNT_W-1:0] position
);
    logic [1:0] cur_pair;
    logic [1:0] prev_pair;
    step_e      step;

    assign cur_pair = {phase_a, phase_b};

    qdec_phase_reg u_phase (
        .clk     (clk),
        .rst     (rst),
        .phase_i (cur_pair),
        .prev_o  (prev_pair)
    );

    qdec_step u_step (
        .prev_i (prev_pair),
        .cur_i  (cur_pair),
        .step_o (step)
    );

    qdec_count #(.CNT_W(CNT_W)) u_count (
        .clk     (clk),
        .rst     (rst),
        .step_i  (step),
        .count_o (position)
    );

    // R2: 00 -> 10 is a forward step
    a_r2_forward: assert property (@(posedge clk) disable iff (rst)
        (prev_pair == 2'b00 && cur_pair == 2'b10)
        |=> (position == CNT_W'($past(position) + 1'b1)));

    // R3: 00 -> 01 is a reverse step
    a_r3_reverse: assert property (@(posedge clk) disable iff (rst)
        (prev_pair == 2'b00 && cur_pair == 2'b01)
        |=> (position == CNT_W'($past(position) - 1'b1)));

    // R6: unchanged pair holds the count
    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        (cur_pair == prev_pair) |=> $stable(position));

    // R7: double jump holds the count
    a_r7_double_jump: assert property (@(posedge clk) disable iff (rst)
        ((cur_pair ^ prev_pair) == 2'b11) |=> $stable(position));

endmodule

// File: tb/quad_position_counter_tb_top.sv
module quad_position_counter_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 22;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pa  = 1'b0;
    logic pb  = 1'b0;
    logic [2:0] pos3;
    logic [7:0] pos8;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    quad_position_counter #(.CNT_W(3)) dut_i (
        .clk(clk), .rst(rst), .phase_a(pa), .phase_b(pb), .position(pos3));

    quad_position_counter dut8_i (
        .clk(clk), .rst(rst), .phase_a(pa), .phase_b(pb), .position(pos8));

    // {rst, A, B, expected at width 3, expected at width 8}
    localparam logic [13:0] VEC [NVEC] = '{
        {1'b1, 2'b00, 3'd0, 8'd0},   // R8 reset
        {1'b0, 2'b00, 3'd0, 8'd0},   // R6 hold
        {1'b0, 2'b10, 3'd1, 8'd1},   // R2
        {1'b0, 2'b11, 3'd2, 8'd2},
        {1'b0, 2'b01, 3'd3, 8'd3},
        {1'b0, 2'b00, 3'd4, 8'd4},
        {1'b0, 2'b10, 3'd5, 8'd5},
        {1'b0, 2'b11, 3'd6, 8'd6},
        {1'b0, 2'b01, 3'd7, 8'd7},
        {1'b0, 2'b00, 3'd0, 8'd8},   // R4 wrap at width 3
        {1'b0, 2'b00, 3'd0, 8'd8},   // R6
        {1'b0, 2'b01, 3'd7, 8'd7},   // R3, R5 at width 3
        {1'b0, 2'b11, 3'd6, 8'd6},
        {1'b0, 2'b10, 3'd5, 8'd5},
        {1'b0, 2'b00, 3'd4, 8'd4},
        {1'b0, 2'b11, 3'd4, 8'd4},   // R7 00->11
        {1'b0, 2'b00, 3'd4, 8'd4},   // R7 11->00
        {1'b0, 2'b10, 3'd5, 8'd5},
        {1'b0, 2'b01, 3'd5, 8'd5},   // R7 10->01
        {1'b0, 2'b11, 3'd4, 8'd4},   // R7 next step counts from 01
        {1'b1, 2'b10, 3'd0, 8'd0},   // R8 reset with inputs 10
        {1'b0, 2'b10, 3'd1, 8'd1}    // R9 first edge decodes vs 00
    };

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic drive(input logic r, input logic [1:0] ab);
        rst = r;
        pa  = ab[1];
        pb  = ab[0];
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures",
                     n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        @(negedge clk);
        // table walk: drive at a falling edge, check at the next one
        for (int i = 0; i < NVEC; i++) begin
            drive(VEC[i][13], VEC[i][12:11]);
            @(negedge clk);
            check($sformatf("R1/R2-R9 w3 row %0d", i), int'(pos3), int'(VEC[i][10:8]));
            check($sformatf("R1/R2-R9 w8 row %0d", i), int'(pos8), int'(VEC[i][7:0]));
        end

        // R10: no change before the edge, change right after it
        drive(1'b0, 2'b11);          // 10 -> 11, count 1 -> 2
        #2;
        check("R10 before edge w3", int'(pos3), 1);
        @(posedge clk); #1;
        check("R10 after edge w3", int'(pos3), 2);
        check("R10 after edge w8", int'(pos8), 2);

        // R8: reset mid-cycle clears at once, without a clock edge
        @(negedge clk); #1;
        rst = 1'b1;
        #1;
        check("R8 async clear w3", int'(pos3), 0);
        check("R8 async clear w8", int'(pos8), 0);

        // R5 / R4 at width 8: wrap from zero down and back up
        @(negedge clk);
        drive(1'b1, 2'b00);
        @(negedge clk);
        drive(1'b0, 2'b00);
        @(negedge clk);
        check("R6 after release", int'(pos8), 0);
        drive(1'b0, 2'b01);
        @(negedge clk);
        check("R5 wrap down w8", int'(pos8), 255);
        check("R5 wrap down w3", int'(pos3), 7);
        drive(1'b0, 2'b00);
        @(negedge clk);
        check("R4 wrap up w8", int'(pos8), 0);
        check("R4 wrap up w3", int'(pos3), 0);

        // R7: 01 <-> 10 double jump in the other direction, then R3
        drive(1'b0, 2'b10);
        @(negedge clk);
        check("R2 step w8", int'(pos8), 1);
        drive(1'b0, 2'b01);
        @(negedge clk);
        check("R7 10->01 hold w8", int'(pos8), 1);
        drive(1'b0, 2'b10);
        @(negedge clk);
        check("R7 01->10 hold w8", int'(pos8), 1);
        drive(1'b0, 2'b00);
        @(negedge clk);
        check("R3 10->00 down w8", int'(pos8), 0);

        finish_run();
    end

    initial begin
        #(CLK_PERIOD * 5000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule